// File: doc/BRIEF.md
# CEC Bus Frame Receiver with Acknowledge

This block listens to a single open-drain CEC line and turns the pulse-width code on it into bytes. All timing runs on a one-microsecond enable (`tick_us`). The block does the following:

- It checks the start bit against a low-phase minimum and a total-length maximum.
- It samples every data bit at a fixed delay after the bit's falling edge.
- It splits each group of ten bit slots into eight payload bits, an end-of-message flag and an acknowledge slot.

The block answers the acknowledge slot by pulling the line low when the frame is directed at one of its logical addresses. Those addresses are held as a 16-bit one-hot mask. A bit period that ends too early is treated as a bus error, and the block signals it by holding the line low for one and a half nominal bit periods.

When a frame ends cleanly, the collected bytes stay on `frame_data` together with a byte count on `frame_len`, and `frame_valid` pulses for one clock. The storage is cleared at the next start bit. The consumer must therefore copy the frame before the next frame begins.

The raw line input passes through a two-flop synchronizer. A single microsecond counter restarts on every falling edge of the line, and all timing decisions compare against it. All thresholds are parameters given in microseconds.

Top module: `cecr_frame_rx`

## Requirements
- R1: After reset `drive_low` is 0, `frame_valid` is 0 and `frame_len` is 0.
- R2: A start bit whose low phase is shorter than START_LOW_MIN (default 3500 µs) is dropped. The block returns to idle, delivers no frame and never drives the line for the bits that follow.
- R3: When the line stays high after a start bit's falling edge for more than START_TOTAL_MAX (default 4700 µs), the frame attempt is abandoned. The next falling edge is then treated as a new start bit, not as the first data bit.
- R4: Each data bit is the line level SAMPLE_AT (default 850 µs) after its falling edge, with high meaning 1. In each ten-slot group, slots 0 to 7 are payload sent most significant first, slot 8 is end-of-message and slot 9 is acknowledge. Byte k appears on `frame_data[8k+7:8k]`.
- R5: If the low nibble of byte 0 is not 15 and that bit of `addr_mask` is set, the block drives `drive_low` high from the acknowledge slot's falling edge for ACK_LOW (default 1500 µs). It does this in every byte of the frame.
- R6: For destination 15 (broadcast), or a destination whose mask bit is clear, the block never drives during the acknowledge slot. This holds even when mask bit 15 is set.
- R7: After the acknowledge slot of a byte whose end-of-message bit was 1, the block checks the line at ACK_DONE (default 1750 µs) after that slot's falling edge. If the line is high there, `frame_valid` pulses for exactly one clock with `frame_len` equal to the byte count, and the frame is delivered whether or not it was acknowledged.
- R8: If the line stays high for more than BIT_MAX (default 2750 µs) after a data bit's falling edge, the frame is dropped with no delivery, and the next start bit is received normally.
- R9: A falling edge that arrives less than BIT_MIN (default 2050 µs) after the previous data-bit edge makes the block drive the line low for ERR_LOW (default 3600 µs). It then returns to idle and delivers no frame.
- R10: A frame with more than MAX_BYTES (16) bytes keeps its first 16 bytes and reports `frame_len` = 16.
- R11: The byte storage is cleared at every accepted start bit, so a short frame that follows a long one reads zero in all higher byte positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_us | input | 1 | One-cycle enable once per microsecond |
| line_in | input | 1 | Raw CEC line level (1 = released/high) |
| addr_mask | input | 16 | One bit per own logical address, bit n = address n |
| drive_low | output | 1 | 1 pulls the open-drain line low |
| frame_valid | output | 1 | One-clock pulse when a frame is complete |
| frame_len | output | 5 | Number of stored bytes of the last frame (1 to 16) |
| frame_data | output | 128 | Stored bytes, byte k on bits 8k+7 down to 8k |

## Verification
The bench runs a bus model that ANDs its own pull-down with the block's. This lets it observe the acknowledge level from the initiator's side, and it covers directed, broadcast and foreign frames with bit 15 of the mask set. A block that decoded broadcast like any other address would pull the acknowledge slot low on broadcasts. A block that checked the wrong nibble would fail to pull it low on directed frames.

The bench also tests a short start, an over-long start and a mid-frame stall. A receiver that missed the start checks would treat later edges as data and deliver a frame that should not exist. A receiver that missed the stall check would carry stale bits into the next frame.

Two further corner cases are covered. A too-short bit must produce a long error pull that then ends. An 18-byte frame followed by a one-byte frame exposes both missing length saturation and missing storage clearing.

// File: rtl/cecr_pkg.sv
package cecr_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START_LO,
    S_START_HI,
    S_BIT_LO,
    S_BIT_HI,
    S_ACK_DRV,
    S_ACK_WAIT,
    S_FINISH,
    S_ERR
  } rx_state_t;

  localparam int SLOTS_PER_BYTE = 10;
  localparam int EOM_SLOT       = 8;
  localparam int ACK_SLOT       = 9;
  localparam int NUM_LADDR      = 16;

endpackage

// File: rtl/cecr_line_sync.sv
module cecr_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall
);

  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= line_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign line_s = sync_q;
  assign fall   = prev_q & ~sync_q;

endmodule

// File: rtl/cecr_us_timer.sv
module cecr_us_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  output logic [TW-1:0] cnt
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          at_top;

  assign at_top = &cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (tick && !at_top)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/cecr_frame_store.sv
module cecr_frame_store #(
  parameter int MAX_BYTES = 16,
  parameter int IDXW      = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr,
  input  logic [IDXW-1:0]        wr_idx,
  input  logic [2:0]             wr_pos,
  input  logic                   wr_val,
  output logic [MAX_BYTES*8-1:0] data
);

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    logic       hit;

    assign hit = wr && (wr_idx == IDXW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byte_q <= '0;
      else if (clr)
        byte_q <= '0;
      else if (hit)
        byte_q[wr_pos] <= wr_val;
    end

    assign data[8*g +: 8] = byte_q;
  end

endmodule

// File: rtl/cecr_frame_rx.sv
module cecr_frame_rx
  import cecr_pkg::*;
#(
  parameter int TW              = 16,
  parameter int MAX_BYTES       = 16,
  parameter int START_LOW_MIN   = 3500,
  parameter int START_TOTAL_MAX = 4700,
  parameter int SAMPLE_AT       = 850,
  parameter int BIT_MIN         = 2050,
  parameter int BIT_MAX         = 2750,
  parameter int ACK_LOW         = 1500,
  parameter int ACK_DONE        = 1750,
  parameter int ERR_LOW         = 3600,
  localparam int IDXW           = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_us,
  input  logic                   line_in,
  input  logic [NUM_LADDR-1:0]   addr_mask,
  output logic                   drive_low,
  output logic                   frame_valid,
  output logic [IDXW-1:0]        frame_len,
  output logic [MAX_BYTES*8-1:0] frame_data
);

  localparam logic [TW-1:0]   T_START_MIN = TW'(START_LOW_MIN);
  localparam logic [TW-1:0]   T_START_MAX = TW'(START_TOTAL_MAX);
  localparam logic [TW-1:0]   T_SAMPLE    = TW'(SAMPLE_AT);
  localparam logic [TW-1:0]   T_BIT_MIN   = TW'(BIT_MIN);
  localparam logic [TW-1:0]   T_BIT_MAX   = TW'(BIT_MAX);
  localparam logic [TW-1:0]   T_ACK_LOW   = TW'(ACK_LOW);
  localparam logic [TW-1:0]   T_ACK_DONE  = TW'(ACK_DONE);
  localparam logic [TW-1:0]   T_ERR_LOW   = TW'(ERR_LOW);
  localparam logic [IDXW-1:0] IDX_CAP     = IDXW'(MAX_BYTES);
  localparam logic [3:0]      SL_EOM      = 4'(EOM_SLOT);
  localparam logic [3:0]      SL_ACK      = 4'(ACK_SLOT);
  localparam logic [3:0]      DEST_BCAST  = 4'(NUM_LADDR - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m      <= 1'b1;
      rst_sync_n <= rst_m;
    end
  end

  logic          line_s, fall;
  logic [TW-1:0] cnt;

  cecr_line_sync i_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .line_in (line_in),
    .line_s  (line_s),
    .fall    (fall)
  );

  cecr_us_timer #(.TW(TW)) i_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick_us),
    .restart (fall),
    .cnt     (cnt)
  );

  rx_state_t       st, st_n;
  logic [3:0]      slot, slot_n;
  logic [IDXW-1:0] idx, idx_n;
  logic            eom, eom_n;
  logic [IDXW-1:0] len_q, len_n;
  logic            valid_q, valid_n;
  logic            st_clr, st_wr;

  logic [3:0]      dest;
  logic            ack_me;
  logic [IDXW-1:0] idx_inc;
  logic [3:0]      slot_inc;

  cecr_frame_store #(.MAX_BYTES(MAX_BYTES), .IDXW(IDXW)) i_store (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (st_clr),
    .wr     (st_wr),
    .wr_idx (idx),
    .wr_pos (3'd7 - slot[2:0]),
    .wr_val (line_s),
    .data   (frame_data)
  );

  assign dest     = frame_data[3:0];
  assign ack_me   = (dest != DEST_BCAST) && addr_mask[dest];
  assign idx_inc  = (idx >= IDX_CAP) ? idx : idx + 1'b1;
  assign slot_inc = slot + 4'd1;

  always_comb begin
    st_n    = st;
    slot_n  = slot;
    idx_n   = idx;
    eom_n   = eom;
    len_n   = len_q;
    valid_n = 1'b0;
    st_clr  = 1'b0;
    st_wr   = 1'b0;
    case (st)
      S_IDLE: begin
        if (fall) begin
          st_n   = S_START_LO;
          st_clr = 1'b1;
          slot_n = '0;
          idx_n  = '0;
          eom_n  = 1'b0;
          len_n  = '0;
        end
      end
      S_START_LO: begin
        if (line_s)
          st_n = (cnt < T_START_MIN) ? S_IDLE : S_START_HI;
      end
      S_START_HI: begin
        if (fall) begin
          st_n   = S_BIT_LO;
          slot_n = '0;
          idx_n  = '0;
        end else if (line_s && cnt > T_START_MAX) begin
          st_n = S_IDLE;
        end
      end
      S_BIT_LO: begin
        if (fall) begin
          st_n = S_ERR;
        end else if (cnt >= T_SAMPLE) begin
          st_n = S_BIT_HI;
          if (slot < SL_EOM) begin
            st_wr = (idx < IDX_CAP);
          end else if (slot == SL_EOM) begin
            eom_n = line_s;
            len_n = idx_inc;
          end
        end
      end
      S_BIT_HI: begin
        if (fall) begin
          if (cnt < T_BIT_MIN) begin
            st_n = S_ERR;
          end else if (slot == SL_ACK) begin
            st_n   = S_BIT_LO;
            slot_n = '0;
            idx_n  = idx_inc;
          end else begin
            slot_n = slot_inc;
            if (slot_inc == SL_ACK)
              st_n = ack_me ? S_ACK_DRV : S_ACK_WAIT;
            else
              st_n = S_BIT_LO;
          end
        end else if (line_s && cnt > T_BIT_MAX) begin
          st_n = S_IDLE;
        end
      end
      S_ACK_DRV: begin
        if (cnt >= T_ACK_LOW)
          st_n = S_ACK_WAIT;
      end
      S_ACK_WAIT: begin
        if (fall) begin
          st_n = S_ERR;
        end else if (cnt >= T_ACK_DONE) begin
          if (line_s && eom) begin
            st_n    = S_FINISH;
            valid_n = 1'b1;
          end else begin
            st_n = S_BIT_HI;
          end
        end
      end
      S_FINISH: begin
        if (cnt >= T_BIT_MIN)
          st_n = S_IDLE;
      end
      S_ERR: begin
        if (cnt >= T_ERR_LOW)
          st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st      <= S_IDLE;
      slot    <= '0;
      idx     <= '0;
      eom     <= 1'b0;
      len_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      st      <= st_n;
      slot    <= slot_n;
      idx     <= idx_n;
      eom     <= eom_n;
      len_q   <= len_n;
      valid_q <= valid_n;
    end
  end

  assign drive_low   = (st == S_ACK_DRV) || (st == S_ERR);
  assign frame_valid = valid_q;
  assign frame_len   = len_q;

endmodule

// File: rtl/cecr_frame_rx_chk.sv
module cecr_frame_rx_chk #(
  parameter int TW        = 16,
  parameter int ACK_LOW   = 1500,
  parameter int MAX_BYTES = 16,
  parameter int IDXW      = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fall,
  input logic            line_s,
  input logic [TW-1:0]   cnt,
  input logic            drive_low,
  input logic            frame_valid,
  input logic [IDXW-1:0] frame_len
);

  // R5: a pull-down only ever starts on the cycle after a detected falling edge
  a_r5_drive_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> $past(fall));

  // R5 / R9: no pull-down is released before the acknowledge time has run out
  a_r5_drive_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> ($past(cnt) >= TW'(ACK_LOW)));

  // R7: delivery is a single-cycle pulse
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R7: delivery only follows a released line
  a_r7_valid_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(line_s));

  // R7: a delivered frame carries at least one byte
  a_r7_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (frame_len != '0));

  // R10: reported length never exceeds the storage
  a_r10_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_len <= IDXW'(MAX_BYTES));

endmodule

bind cecr_frame_rx cecr_frame_rx_chk #(
  .TW        (TW),
  .ACK_LOW   (ACK_LOW),
  .MAX_BYTES (MAX_BYTES),
  .IDXW      (IDXW)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .fall        (fall),
  .line_s      (line_s),
  .cnt         (cnt),
  .drive_low   (drive_low),
  .frame_valid (frame_valid),
  .frame_len   (frame_len)
);

// File: tb/test_cecr_frame_rx.sv
module test_cecr_frame_rx;

  localparam int MAXB = 16;
  localparam int IW   = 5;
  // thresholds scaled down by ten; one tick per clock
  localparam int P_SLO  = 350;
  localparam int P_STM  = 470;
  localparam int P_SMP  = 85;
  localparam int P_BMIN = 205;
  localparam int P_BMAX = 275;
  localparam int P_ACKL = 150;
  localparam int P_ACKD = 175;
  localparam int P_ERRL = 360;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, tick_us, tb_low, bus;
  logic [15:0]     mask;
  logic            drive_low, frame_valid;
  logic [IW-1:0]   frame_len;
  logic [MAXB*8-1:0] frame_data;

  assign bus = ~(tb_low | drive_low);

  cecr_frame_rx #(
    .START_LOW_MIN(P_SLO), .START_TOTAL_MAX(P_STM), .SAMPLE_AT(P_SMP),
    .BIT_MIN(P_BMIN), .BIT_MAX(P_BMAX), .ACK_LOW(P_ACKL),
    .ACK_DONE(P_ACKD), .ERR_LOW(P_ERRL)
  ) i_cecr_frame_rx (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .line_in(bus),
    .addr_mask(mask), .drive_low(drive_low), .frame_valid(frame_valid),
    .frame_len(frame_len), .frame_data(frame_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [MAXB*8-1:0] q_data[$];
  int                q_len[$];
  logic [7:0]        fb [0:17];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      if (q_len.size() == 0) begin
        check(1'b0, "R7", "unexpected frame_valid", 128'(frame_len), 128'd0);
      end else begin
        int el;
        logic [MAXB*8-1:0] ed;
        el = q_len.pop_front();
        ed = q_data.pop_front();
        check(frame_len == IW'(el), "R7 R10", "frame_len", 128'(frame_len), 128'(el));
        check(frame_data == ed, "R4 R11", "frame_data", frame_data, ed);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input bit v);
    tb_low = 1'b1; wait_n(v ? 60 : 150);
    tb_low = 1'b0; wait_n(v ? 180 : 90);
  endtask

  task automatic put_start(input int lo, input int hi);
    tb_low = 1'b1; wait_n(lo);
    tb_low = 1'b0; wait_n(hi);
  endtask

  // initiator sends a 1 in the acknowledge slot and looks at the line
  task automatic ack_slot(input bit exp_drive, input string req);
    tb_low = 1'b1; wait_n(60);
    tb_low = 1'b0; wait_n(40);
    check(bus == !exp_drive, req, "acknowledge slot line level", 128'(bus), 128'(!exp_drive));
    wait_n(140);
  endtask

  task automatic put_body(input int n, input bit exp_ack, input string req);
    for (int i = 0; i < n; i++) begin
      for (int j = 7; j >= 0; j--) put_bit(fb[i][j]);
      put_bit(i == n - 1);
      ack_slot(exp_ack, req);
    end
    wait_n(300);
  endtask

  task automatic put_frame(input int n, input bit exp_ack, input string req);
    logic [MAXB*8-1:0] e;
    e = '0;
    for (int k = 0; k < n && k < MAXB; k++) e[8*k +: 8] = fb[k];
    q_data.push_back(e);
    q_len.push_back(n > MAXB ? MAXB : n);
    put_start(370, 80);
    put_body(n, exp_ack, req);
    check(q_len.size() == 0, req, "frame delivered", 128'(q_len.size()), 128'd0);
  endtask

  initial begin
    wait_n(200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_us = 1'b1; tb_low = 1'b0; mask = 16'h8010;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    // R1 reset state
    check(drive_low == 1'b0, "R1", "drive_low", 128'(drive_low), 128'd0);
    check(frame_valid == 1'b0, "R1", "frame_valid", 128'(frame_valid), 128'd0);
    check(frame_len == '0, "R1", "frame_len", 128'(frame_len), 128'd0);
    wait_n(20);

    // R4 R5 R7: directed to address 4, acknowledged in both bytes
    fb[0] = 8'h14; fb[1] = 8'hA5;
    put_frame(2, 1'b1, "R5");

    // R6: broadcast with mask bit 15 set must not be acknowledged
    fb[0] = 8'h4F; fb[1] = 8'h3C;
    put_frame(2, 1'b0, "R6");

    // R6: foreign destination 7, delivered but not acknowledged
    fb[0] = 8'h47;
    put_frame(1, 1'b0, "R6");

    // R2: start low too short; following bits must not form a frame
    fb[0] = 8'h14;
    put_start(200, 60);
    put_body(1, 1'b0, "R2");
    check(drive_low == 1'b0, "R2", "no drive after short start", 128'(drive_low), 128'd0);

    // R3: start high too long; following edge is not a data bit
    put_start(370, 150);
    put_body(1, 1'b0, "R3");
    check(drive_low == 1'b0, "R3", "no drive after long start", 128'(drive_low), 128'd0);

    // R8: stall in the middle of a frame, then a normal frame
    put_start(370, 80);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    wait_n(400);
    check(drive_low == 1'b0, "R8", "no drive after stall", 128'(drive_low), 128'd0);
    fb[0] = 8'h04; fb[1] = 8'h5A;
    put_frame(2, 1'b1, "R8");

    // R9: next falling edge after only 150 ticks
    put_start(370, 80);
    tb_low = 1'b1; wait_n(60);
    tb_low = 1'b0; wait_n(90);
    tb_low = 1'b1; wait_n(60);
    tb_low = 1'b0; wait_n(140);
    check(drive_low == 1'b1, "R9", "error pull active", 128'(drive_low), 128'd1);
    check(bus == 1'b0, "R9", "line held low", 128'(bus), 128'd0);
    wait_n(220);
    check(drive_low == 1'b0, "R9", "error pull released", 128'(drive_low), 128'd0);
    wait_n(300);

    // R10: 18 bytes, only 16 kept
    fb[0] = 8'h14;
    for (int k = 1; k < 18; k++) fb[k] = 8'(k * 17 + 3);
    put_frame(18, 1'b1, "R10");

    // R11: short frame after the long one reads zeros above byte 0
    fb[0] = 8'h0F;
    put_frame(1, 1'b0, "R11");

    check(q_len.size() == 0, "R7", "no pending expected frames", 128'(q_len.size()), 128'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule